// File: doc/BRIEF.md
# FIR Coefficient Shadow Bank Controller

This block stores the tap coefficients of a read-channel equalizer filter in two copies, a staging copy and a live copy. There is one pair of copies for the main-channel tap set and one for the auxiliary-channel tap set. A microcontroller loads a 5-bit address pointer and then streams coefficient bytes. Each byte lands in the staging copy, and the pointer steps forward after every byte transfer. Reads by the microcontroller always come from the live copy.

To apply a new set, the microcontroller first raises an update request that names the set it wants: main or aux. The block then waits for a frame-boundary strobe. On that strobe it copies all ten staging entries of the named set into the live copy in one clock. It clears the request flag and raises a "swapped" status bit. That status bit drops again when the next main-set coefficient byte is written. The filter datapath reads the live copy through its own registered tap port.

Reset returns the pointer and the flags to their idle state. It leaves every coefficient value untouched.

Top module: `coef_bank_ctrl`

## Requirements
- R1: After reset, `cnt_q` reads 0, `upd_pending` is 0, `bank_swapped` is 0 and `coef_rdata` is 0.
- R2: A `cnt_load` pulse sets the pointer to `cnt_wdata`. `cnt_q` shows the pointer in bits 4:0, and bits 7:5 always read as 0.
- R3: Each `coef_wr` or `coef_rd` cycle advances the pointer by one, and the pointer wraps from 31 to 0. A load in the same cycle takes priority over the step.
- R4: A write at pointer 0..9 goes to main staging entry 0..9. A write at pointer 16..25 goes to aux staging entry 0..9. Live values do not change until a switch.
- R5: A `coef_rd` returns the live value at the pointer on `coef_rdata` one clock later. The result is 0 for any pointer outside 0..9 and 16..25.
- R6: Writes at pointers 10..15 and 26..31 change no entry of either set.
- R7: A switch takes place only on a cycle where `frame_strobe` is 1 while `upd_pending` is already 1. A strobe with no pending request changes nothing.
- R8: A switch copies all ten staging entries of the set chosen by `upd_aux` at request time (0 = main, 1 = aux) into that set's live copy. The other set is left alone.
- R9: `upd_req` sets `upd_pending`, and the switch clears it in the clock after the strobe.
- R10: `bank_swapped` goes to 1 after a switch. It goes back to 0 after a write at a main pointer (0..9). Aux writes do not clear it.
- R11: Reset does not change any staging or live coefficient.
- R12: `fir_coef` shows the live entry selected by `fir_aux`/`fir_tap` one clock later. The value is 0 when `fir_tap` is 10 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_load | input | 1 | Load the address pointer |
| cnt_wdata | input | 5 | Value to load into the pointer |
| cnt_q | output | 8 | Pointer readback, upper three bits zero |
| coef_wr | input | 1 | Write a coefficient byte at the pointer |
| coef_wdata | input | 8 | Coefficient byte to write |
| coef_rd | input | 1 | Read the live coefficient at the pointer |
| coef_rdata | output | 8 | Registered read result |
| upd_req | input | 1 | Raise the update request |
| upd_aux | input | 1 | Set chosen by the request: 0 main, 1 aux |
| upd_pending | output | 1 | Update request outstanding |
| frame_strobe | input | 1 | Frame-boundary switch opportunity |
| bank_swapped | output | 1 | Switch has happened since the last main write |
| fir_aux | input | 1 | Filter port set select |
| fir_tap | input | 4 | Filter port tap index |
| fir_coef | output | 8 | Registered live coefficient for the filter |

## Verification
The bench writes into staging and reads before the switch, so a design that wrote straight into the live copy would return the new byte too early. It fires strobes with no request pending and requests only the aux set; a design that switched on every strobe, or copied both sets, would show changed main values. It writes at the gap pointers 10..15 and 26..31 and then reads every entry; a decoder that only looked at the low bits would alias those writes onto real taps. It checks that aux writes leave the status bit set, that the pointer wraps at 31, and that a reset leaves the coefficients intact.

// File: rtl/coef_bank_pkg.sv
package coef_bank_pkg;
  localparam int COEF_W = 8;
  localparam int NTAPS  = 10;
  localparam int ADDR_W = 5;
  localparam int TAP_W  = 4;
  localparam int NSETS  = 2;

  // set 0 (main) lives where addr[4]==0, set 1 (aux) where addr[4]==1
  function automatic logic addr_hits(input logic [ADDR_W-1:0] a, input logic set_bit);
    return (a[ADDR_W-1] == set_bit) && (a[TAP_W-1:0] < TAP_W'(NTAPS));
  endfunction
endpackage

// File: rtl/coef_addr_ctr.sv
module coef_addr_ctr #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] ld_val,
  input  logic          step,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= ld_val;
    else if (step) q <= q + AW'(1);
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> q == $past(ld_val));
  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> q == AW'($past(q) + AW'(1)));
endmodule

// File: rtl/coef_bank_pair.sv
module coef_bank_pair #(
  parameter int W  = 8,
  parameter int N  = 10,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic          copy,
  input  logic [IW-1:0] mic_idx,
  output logic [W-1:0]  mic_q,
  input  logic [IW-1:0] fir_idx,
  output logic [W-1:0]  fir_q
);
  logic [N-1:0][W-1:0] stage_q;
  logic [N-1:0][W-1:0] live_q;

  // no reset: coefficients survive system reset
  always_ff @(posedge clk) begin
    if (wr_en && (wr_idx < IW'(N))) stage_q[wr_idx] <= wr_data;
    if (copy) live_q <= stage_q;
  end

  always_comb begin
    mic_q = '0;
    fir_q = '0;
    if (mic_idx < IW'(N)) mic_q = live_q[mic_idx];
    if (fir_idx < IW'(N)) fir_q = live_q[fir_idx];
  end

  assert_live_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !copy |=> $stable(live_q));
  assert_copy_all_R8: assert property (@(posedge clk) disable iff (rst)
    copy |=> live_q == $past(stage_q));
endmodule

// File: rtl/coef_switch_ctl.sv
module coef_switch_ctl (
  input  logic clk,
  input  logic rst,
  input  logic upd_req,
  input  logic upd_aux,
  input  logic frame_strobe,
  input  logic main_wr,
  output logic pending,
  output logic sel_aux,
  output logic do_switch,
  output logic swapped
);
  assign do_switch = frame_strobe && pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      sel_aux <= 1'b0;
      swapped <= 1'b0;
    end else begin
      if (upd_req) begin
        pending <= 1'b1;
        sel_aux <= upd_aux;
      end else if (do_switch) begin
        pending <= 1'b0;
      end
      if (do_switch)    swapped <= 1'b1;
      else if (main_wr) swapped <= 1'b0;
    end
  end

  assert_pend_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (frame_strobe && pending && !upd_req) |=> !pending);
  assert_fell_only_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(pending) |-> $past(frame_strobe));
  assert_swap_rise_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(swapped) |-> $past(frame_strobe && pending));
  assert_swap_fall_R10: assert property (@(posedge clk) disable iff (rst)
    (main_wr && !do_switch) |=> !swapped);
endmodule

// File: rtl/coef_bank_ctrl.sv
module coef_bank_ctrl
  import coef_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_load,
  input  logic [ADDR_W-1:0] cnt_wdata,
  output logic [7:0]        cnt_q,
  input  logic              coef_wr,
  input  logic [COEF_W-1:0] coef_wdata,
  input  logic              coef_rd,
  output logic [COEF_W-1:0] coef_rdata,
  input  logic              upd_req,
  input  logic              upd_aux,
  output logic              upd_pending,
  input  logic              frame_strobe,
  output logic              bank_swapped,
  input  logic              fir_aux,
  input  logic [TAP_W-1:0]  fir_tap,
  output logic [COEF_W-1:0] fir_coef
);
  logic [ADDR_W-1:0] ptr;
  logic              sel_aux, do_switch, main_wr;
  logic [COEF_W-1:0] set_mic [NSETS];
  logic [COEF_W-1:0] set_fir [NSETS];

  coef_addr_ctr #(.AW(ADDR_W)) u_ctr (
    .clk(clk), .rst(rst), .load(cnt_load), .ld_val(cnt_wdata),
    .step(coef_wr || coef_rd), .q(ptr)
  );
  assign cnt_q = {{(8-ADDR_W){1'b0}}, ptr};

  assign main_wr = coef_wr && addr_hits(ptr, 1'b0);

  coef_switch_ctl u_sw (
    .clk(clk), .rst(rst), .upd_req(upd_req), .upd_aux(upd_aux),
    .frame_strobe(frame_strobe), .main_wr(main_wr), .pending(upd_pending),
    .sel_aux(sel_aux), .do_switch(do_switch), .swapped(bank_swapped)
  );

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    coef_bank_pair #(.W(COEF_W), .N(NTAPS), .IW(TAP_W)) u_bank (
      .clk(clk), .rst(rst),
      .wr_en(coef_wr && addr_hits(ptr, 1'(s))),
      .wr_idx(ptr[TAP_W-1:0]), .wr_data(coef_wdata),
      .copy(do_switch && (sel_aux == 1'(s))),
      .mic_idx(ptr[TAP_W-1:0]), .mic_q(set_mic[s]),
      .fir_idx(fir_tap), .fir_q(set_fir[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      coef_rdata <= '0;
      fir_coef   <= '0;
    end else begin
      if (coef_rd) coef_rdata <= set_mic[ptr[ADDR_W-1]];
      fir_coef <= set_fir[fir_aux];
    end
  end

  assert_rd_gap_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (coef_rd && ptr[TAP_W-1:0] >= TAP_W'(NTAPS)) |=> coef_rdata == '0);
  assert_fir_gap_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (fir_tap >= TAP_W'(NTAPS)) |=> fir_coef == '0);
endmodule

// File: tb/coef_bank_ctrl_test.sv
module coef_bank_ctrl_test;
  logic clk = 0, rst = 1;
  logic cnt_load = 0, coef_wr = 0, coef_rd = 0, upd_req = 0, upd_aux = 0;
  logic frame_strobe = 0, fir_aux = 0;
  logic [4:0] cnt_wdata = 0;
  logic [7:0] coef_wdata = 0;
  logic [3:0] fir_tap = 0;
  logic [7:0] cnt_q, coef_rdata, fir_coef;
  logic upd_pending, bank_swapped;

  int checks = 0, errors = 0;
  logic [7:0] m_stage [2][10];
  logic [7:0] m_live  [2][10];
  logic [4:0] m_ptr;

  always #4 clk = ~clk;

  coef_bank_ctrl uut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic do_reset();
    rst = 1; tick(); tick(); rst = 0; m_ptr = 0;
  endtask

  task automatic set_ptr(logic [4:0] a);
    cnt_load = 1; cnt_wdata = a; tick(); cnt_load = 0; m_ptr = a;
  endtask

  task automatic wr(logic [7:0] d);
    coef_wr = 1; coef_wdata = d; tick(); coef_wr = 0;
    if (m_ptr[3:0] < 10) m_stage[m_ptr[4]][m_ptr[3:0]] = d;
    m_ptr = m_ptr + 1;
  endtask

  task automatic rd_chk(string req);
    logic [7:0] e;
    e = (m_ptr[3:0] < 10) ? m_live[m_ptr[4]][m_ptr[3:0]] : 8'h00;
    coef_rd = 1; tick(); coef_rd = 0;
    chk(req, coef_rdata, e);
    m_ptr = m_ptr + 1;
  endtask

  task automatic request(logic aux);
    upd_req = 1; upd_aux = aux; tick(); upd_req = 0;
  endtask

  task automatic strobe(logic expect_switch, logic aux);
    frame_strobe = 1; tick(); frame_strobe = 0;
    if (expect_switch) for (int i = 0; i < 10; i++) m_live[aux][i] = m_stage[aux][i];
  endtask

  task automatic read_all(string req);
    set_ptr(0);  for (int i = 0; i < 10; i++) rd_chk(req);
    set_ptr(16); for (int i = 0; i < 10; i++) rd_chk(req);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 cnt", cnt_q, 0);
    chk("R1 pending", {7'b0, upd_pending}, 0);
    chk("R1 swapped", {7'b0, bank_swapped}, 0);
    chk("R1 rdata", coef_rdata, 0);
  endtask

  task automatic t_counter();
    set_ptr(21); chk("R2 load", cnt_q, 8'd21);
    set_ptr(31); chk("R2 top bits zero", cnt_q, 8'd31);
    wr(8'hEE); chk("R3 wrap", cnt_q, 8'd0);
    rd_chk("R5 rd"); chk("R3 rd step", cnt_q, 8'd1);
  endtask

  task automatic t_initial_load();
    set_ptr(0); for (int i = 0; i < 10; i++) wr(8'h10 + 8'(i));
    request(0); chk("R9 pending set", {7'b0, upd_pending}, 1);
    strobe(1, 0);
    chk("R9 pending clr", {7'b0, upd_pending}, 0);
    chk("R10 swapped", {7'b0, bank_swapped}, 1);
    set_ptr(16); for (int i = 0; i < 10; i++) wr(8'hA0 + 8'(i));
    chk("R10 aux keeps", {7'b0, bank_swapped}, 1);
    request(1); strobe(1, 1);
    read_all("R8 load");
  endtask

  task automatic t_shadow();
    set_ptr(3); wr(8'h5A);
    set_ptr(3); rd_chk("R4 staged only");
    chk("R10 main clr", {7'b0, bank_swapped}, 0);
    strobe(0, 0);
    set_ptr(3); rd_chk("R7 no request");
    chk("R7 no swap", {7'b0, bank_swapped}, 0);
    request(0); strobe(1, 0);
    set_ptr(3); rd_chk("R4 after switch");
  endtask

  task automatic t_gaps();
    set_ptr(10); for (int i = 0; i < 6; i++) wr(8'hC0 + 8'(i));
    set_ptr(26); for (int i = 0; i < 6; i++) wr(8'hD0 + 8'(i));
    request(0); strobe(1, 0); request(1); strobe(1, 1);
    read_all("R6 gaps");
    set_ptr(12); rd_chk("R5 gap zero");
    set_ptr(29); rd_chk("R5 gap zero");
  endtask

  task automatic t_isolation();
    set_ptr(0);  for (int i = 0; i < 10; i++) wr(8'h30 + 8'(i));
    set_ptr(16); for (int i = 0; i < 10; i++) wr(8'h60 + 8'(i));
    request(1); strobe(1, 1);
    read_all("R8 aux only");
  endtask

  task automatic t_fir();
    for (int s = 0; s < 2; s++)
      for (int t = 0; t < 12; t += 3) begin
        fir_aux = 1'(s); fir_tap = 4'(t); tick();
        chk("R12 fir", fir_coef, t < 10 ? m_live[s][t] : 8'h00);
      end
  endtask

  task automatic t_reset_keeps();
    do_reset();
    chk("R1 cnt", cnt_q, 0);
    read_all("R11 live kept");
    request(0); strobe(1, 0);
    read_all("R11 staged kept");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_counter();
    t_initial_load();
    t_shadow();
    t_gaps();
    t_isolation();
    t_fir();
    t_reset_keeps();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule